// File: doc/BRIEF.md
# Windowed Aperture Address Translator

This block maps a small host-visible register aperture onto a much larger internal register space. The aperture is divided into a fixed number of equal windows. Each window can be pointed at any dword-aligned location of the internal space by programming its base. A host access names an aperture address. The block works out which window holds it, adds the offset inside that window to the window's byte base, and forwards the result as one internal read or write. Read data, or a fault, comes back to the host.

Every window also holds a function-impersonation word. Its fields travel with each access forwarded through that window. An admin port programs the bases and the impersonation words and issues commands. The commands are: a global invalidate; function impersonation; port impersonation; and port un-impersonation. The lowest windows are reserved, so impersonation commands aimed at them are ignored.

Accesses are sequenced by a four-state machine:
- IDLE accepts a request. It goes to BUS when the selected window is valid and to FAULT when it is not.
- BUS drives the internal request until it is acknowledged, then moves to DONE.
- DONE returns the captured read data and goes back to IDLE.
- FAULT returns the fault pattern with the error flag and goes back to IDLE.

Top module: `apx_top`

## Requirements
- R1: After reset every window base reads 0xFFFFFFFF, `win_valid` is all zeros, every impersonation word is 0 and `host_ready` is 1.
- R2: Admin word address 2*i writes and reads window i's base in dword units. A window is valid, and its `win_valid` bit is set, exactly when its base is not 0xFFFFFFFF.
- R3: An aperture address selects window `host_addr[14:12]`. The forwarded `int_addr` equals the window base shifted left by 2 plus `host_addr[11:0]`, and it stays stable while `int_req` is high.
- R4: A host write through a valid window drives `int_we`=1 and forwards `host_wdata` on `int_wdata`. `host_done` then pulses with `host_err`=0.
- R5: A host read through a valid window returns the `int_rdata` value present at the acknowledge, with `host_err`=0.
- R6: An access through an invalid window never raises `int_req`. In the cycle after acceptance it completes with `host_done`=1, `host_err`=1 and `host_rdata`=0xDEADBEEF.
- R7: Command op 1 (command word at admin word address 2*NUM_WIN; op in bits 1:0, window in bits 7:2, port in bits 15:8, function id in bits 31:16) sets the window's impersonation word as follows: function id in bits 15:0; concrete (bit 16), function-impersonate (bit 17) and port-impersonate (bit 18) set; use-port (bit 19) and port (bits 27:20) cleared.
- R8: Command op 2 keeps the function id. It sets port-impersonate and use-port, loads the port field, and clears concrete and function-impersonate.
- R9: Command op 3 keeps the function id. It sets port-impersonate and clears use-port, port, concrete and function-impersonate.
- R10: Command op 0 returns every window base to 0xFFFFFFFF in one cycle.
- R11: Impersonation commands aimed at windows 0 and 1 leave their words unchanged. A raw write to admin word address 2*i+1 still sets window i's word.
- R12: During a forwarded access `int_imp` carries the impersonation word of the window being accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adm_we | input | 1 | Admin write strobe |
| adm_addr | input | 5 | Admin word address |
| adm_wdata | input | 32 | Admin write data |
| adm_rdata | output | 32 | Admin read data (combinational) |
| host_req | input | 1 | Host access request, taken when host_ready is 1 |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 15 | Aperture-relative byte address |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Machine is idle and accepts a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Completion was a fault |
| host_rdata | output | 32 | Read data or fault pattern, valid with host_done |
| int_req | output | 1 | Internal access request |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | 32 | Translated internal byte address |
| int_wdata | output | 32 | Internal write data |
| int_imp | output | 32 | Impersonation word of the accessed window |
| int_ack | input | 1 | Internal access acknowledge |
| int_rdata | input | 32 | Internal read data, sampled with int_ack |
| win_valid | output | 8 | One bit per window, set when its base is valid |
| imp_all | output | 256 | All impersonation words, window i at bits 32*i+31:32*i |

## Verification
Translation is tried with directed accesses at the first and last byte of a window. These show whether the offset is added to the shifted base or to the raw base. Random accesses then spread over all eight windows while random bases, including the all-ones marker, are written into the general windows. That mix separates window selection errors from validity errors, and forwarded accesses from faults.

The impersonation commands are applied in a sequence of function, port, function again and un-port on one window. Each step only passes when the fields the previous step set are correctly kept or cleared. The same commands are then aimed at a reserved window to show they are ignored there.

// File: rtl/apx_pkg.sv
package apx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_DONE,
        ST_FAULT
    } apx_state_e;

    typedef enum logic [1:0] {
        OP_INVAL_ALL = 2'd0,
        OP_FUNC      = 2'd1,
        OP_PORT      = 2'd2,
        OP_UNPORT    = 2'd3
    } apx_op_e;

    localparam logic [31:0] INVALID_BASE = 32'hFFFF_FFFF;
    localparam logic [31:0] FAULT_DATA   = 32'hDEAD_BEEF;

    // impersonation word layout
    localparam int FID_LSB    = 0;
    localparam int B_CONCRETE = 16;
    localparam int B_PFUNC    = 17;
    localparam int B_PPORT    = 18;
    localparam int B_USEPORT  = 19;
    localparam int PORT_LSB   = 20;
    localparam int PORT_W     = 8;

    // command word layout
    localparam int CMD_WIN_LSB  = 2;
    localparam int CMD_WIN_W    = 6;
    localparam int CMD_PORT_LSB = 8;
    localparam int CMD_FID_LSB  = 16;

    function automatic logic [31:0] imp_func(input logic [15:0] fid);
        logic [31:0] w;
        w = '0;
        w[FID_LSB +: 16] = fid;
        w[B_CONCRETE]    = 1'b1;
        w[B_PFUNC]       = 1'b1;
        w[B_PPORT]       = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] imp_port(input logic [15:0] fid,
                                             input logic [PORT_W-1:0] port);
        logic [31:0] w;
        w = '0;
        w[FID_LSB +: 16]      = fid;
        w[B_PPORT]            = 1'b1;
        w[B_USEPORT]          = 1'b1;
        w[PORT_LSB +: PORT_W] = port;
        return w;
    endfunction

    function automatic logic [31:0] imp_unport(input logic [15:0] fid);
        logic [31:0] w;
        w = '0;
        w[FID_LSB +: 16] = fid;
        w[B_PPORT]       = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/apx_window_table.sv
module apx_window_table
    import apx_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int RSVD    = 2,
    parameter int ADM_AW  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adm_we,
    input  logic [ADM_AW-1:0]     adm_addr,
    input  logic [31:0]           adm_wdata,
    output logic [31:0]           adm_rdata,
    output logic [NUM_WIN*32-1:0] base_flat,
    output logic [NUM_WIN*32-1:0] imp_flat,
    output logic [NUM_WIN-1:0]    win_valid
);
    localparam int WIN_W   = $clog2(NUM_WIN);
    localparam int CMD_IDX = 2 * NUM_WIN;

    logic                 hit_cmd;
    logic                 hit_win;
    logic                 hit_imp;
    logic [WIN_W-1:0]     win_sel;
    apx_op_e              cmd_op;
    logic [CMD_WIN_W-1:0] cmd_win;
    logic [PORT_W-1:0]    cmd_port;
    logic [15:0]          cmd_fid;

    always_comb begin
        hit_cmd  = (adm_addr == ADM_AW'(CMD_IDX));
        hit_win  = ({1'b0, adm_addr} < (ADM_AW+1)'(CMD_IDX));
        hit_imp  = adm_addr[0];
        win_sel  = adm_addr[WIN_W:1];
        cmd_op   = apx_op_e'(adm_wdata[1:0]);
        cmd_win  = adm_wdata[CMD_WIN_LSB +: CMD_WIN_W];
        cmd_port = adm_wdata[CMD_PORT_LSB +: PORT_W];
        cmd_fid  = adm_wdata[CMD_FID_LSB +: 16];
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam bit LOCKED = (i < RSVD);
        logic [31:0] base_q;
        logic [31:0] imp_q;
        logic        base_wr;
        logic        imp_wr;
        logic        cmd_hit;

        always_comb begin
            base_wr = adm_we && hit_win && !hit_imp && (win_sel == WIN_W'(i));
            imp_wr  = adm_we && hit_win &&  hit_imp && (win_sel == WIN_W'(i));
            cmd_hit = adm_we && hit_cmd && (cmd_win == CMD_WIN_W'(i)) && !LOCKED;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q <= INVALID_BASE;
            end else if (base_wr) begin
                base_q <= adm_wdata;
            end else if (adm_we && hit_cmd && cmd_op == OP_INVAL_ALL) begin
                base_q <= INVALID_BASE;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                imp_q <= '0;
            end else if (imp_wr) begin
                imp_q <= adm_wdata;
            end else if (cmd_hit) begin
                unique case (cmd_op)
                    OP_FUNC:   imp_q <= imp_func(cmd_fid);
                    OP_PORT:   imp_q <= imp_port(imp_q[15:0], cmd_port);
                    OP_UNPORT: imp_q <= imp_unport(imp_q[15:0]);
                    default:   imp_q <= imp_q;
                endcase
            end
        end

        assign base_flat[i*32 +: 32] = base_q;
        assign imp_flat[i*32 +: 32]  = imp_q;
        assign win_valid[i]          = (base_q != INVALID_BASE);
    end

    always_comb begin
        adm_rdata = '0;
        if (hit_win) begin
            if (hit_imp) adm_rdata = imp_flat[32*win_sel +: 32];
            else         adm_rdata = base_flat[32*win_sel +: 32];
        end
    end

    // R10
    inval_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_we && hit_cmd && adm_wdata[1:0] == 2'b00) |=> (win_valid == '0));

    // R11
    rsvd_imp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_we && hit_cmd) |=> $stable(imp_flat[RSVD*32-1:0]));

    // R2
    base_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_we && hit_win && !hit_imp && adm_wdata != INVALID_BASE)
        |=> win_valid[$past(win_sel)]);

endmodule

// File: rtl/apx_decode.sv
module apx_decode #(
    parameter int NUM_WIN = 8,
    parameter int OFF_W   = 12,
    parameter int APER_W  = 15
) (
    input  logic [APER_W-1:0]     host_addr,
    input  logic [NUM_WIN*32-1:0] base_flat,
    input  logic [NUM_WIN*32-1:0] imp_flat,
    output logic [31:0]           xl_addr,
    output logic                  xl_ok,
    output logic [31:0]           xl_imp
);
    localparam int WIN_W = APER_W - OFF_W;

    logic [WIN_W-1:0] win_idx;
    logic [OFF_W-1:0] win_off;
    logic [31:0]      base_sel;

    always_comb begin
        win_idx  = host_addr[APER_W-1:OFF_W];
        win_off  = host_addr[OFF_W-1:0];
        base_sel = base_flat[32*win_idx +: 32];
        xl_imp   = imp_flat[32*win_idx +: 32];
        xl_ok    = (base_sel != 32'hFFFF_FFFF);
        xl_addr  = {base_sel[29:0], 2'b00} + 32'(win_off);
    end

endmodule

// File: rtl/apx_access_fsm.sv
module apx_access_fsm
    import apx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    input  logic [31:0] xl_addr,
    input  logic        xl_ok,
    input  logic [31:0] xl_imp,
    input  logic        int_ack,
    input  logic [31:0] int_rdata,
    output logic        host_ready,
    output logic        host_done,
    output logic        host_err,
    output logic [31:0] host_rdata,
    output logic        int_req,
    output logic        int_we,
    output logic [31:0] int_addr,
    output logic [31:0] int_wdata,
    output logic [31:0] int_imp
);
    apx_state_e  st_q, st_d;
    logic [31:0] addr_q, wdata_q, imp_q, rdata_q;
    logic        we_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (host_req) st_d = xl_ok ? ST_BUS : ST_FAULT;
            ST_BUS:   if (int_ack)  st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            ST_FAULT: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            imp_q   <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && host_req && xl_ok) begin
                addr_q  <= xl_addr;
                wdata_q <= host_wdata;
                imp_q   <= xl_imp;
                we_q    <= host_we;
            end
            if (st_q == ST_BUS && int_ack) rdata_q <= int_rdata;
        end
    end

    always_comb begin
        host_ready = (st_q == ST_IDLE);
        host_done  = (st_q == ST_DONE) || (st_q == ST_FAULT);
        host_err   = (st_q == ST_FAULT);
        host_rdata = '0;
        if (st_q == ST_FAULT)     host_rdata = FAULT_DATA;
        else if (st_q == ST_DONE) host_rdata = rdata_q;
        int_req    = (st_q == ST_BUS);
        int_we     = int_req && we_q;
        int_addr   = addr_q;
        int_wdata  = wdata_q;
        int_imp    = imp_q;
    end

    // R6
    fault_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !xl_ok)
        |=> (host_done && host_err && host_rdata == FAULT_DATA && !int_req));

    // R3
    fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && xl_ok) |=> (int_req && int_addr == $past(xl_addr)));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && $past(int_req)) |-> $stable(int_addr));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

endmodule

// File: rtl/apx_top.sv
module apx_top #(
    parameter int NUM_WIN = 8,
    parameter int OFF_W   = 12,
    parameter int RSVD    = 2,
    parameter int ADM_AW  = 5,
    parameter int APER_W  = OFF_W + $clog2(NUM_WIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adm_we,
    input  logic [ADM_AW-1:0]     adm_addr,
    input  logic [31:0]           adm_wdata,
    output logic [31:0]           adm_rdata,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [APER_W-1:0]     host_addr,
    input  logic [31:0]           host_wdata,
    output logic                  host_ready,
    output logic                  host_done,
    output logic                  host_err,
    output logic [31:0]           host_rdata,
    output logic                  int_req,
    output logic                  int_we,
    output logic [31:0]           int_addr,
    output logic [31:0]           int_wdata,
    output logic [31:0]           int_imp,
    input  logic                  int_ack,
    input  logic [31:0]           int_rdata,
    output logic [NUM_WIN-1:0]    win_valid,
    output logic [NUM_WIN*32-1:0] imp_all
);
    logic [NUM_WIN*32-1:0] base_flat;
    logic [31:0]           xl_addr;
    logic [31:0]           xl_imp;
    logic                  xl_ok;

    apx_window_table #(
        .NUM_WIN (NUM_WIN),
        .RSVD    (RSVD),
        .ADM_AW  (ADM_AW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .adm_we    (adm_we),
        .adm_addr  (adm_addr),
        .adm_wdata (adm_wdata),
        .adm_rdata (adm_rdata),
        .base_flat (base_flat),
        .imp_flat  (imp_all),
        .win_valid (win_valid)
    );

    apx_decode #(
        .NUM_WIN (NUM_WIN),
        .OFF_W   (OFF_W),
        .APER_W  (APER_W)
    ) u_decode (
        .host_addr (host_addr),
        .base_flat (base_flat),
        .imp_flat  (imp_all),
        .xl_addr   (xl_addr),
        .xl_ok     (xl_ok),
        .xl_imp    (xl_imp)
    );

    apx_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .xl_addr    (xl_addr),
        .xl_ok      (xl_ok),
        .xl_imp     (xl_imp),
        .int_ack    (int_ack),
        .int_rdata  (int_rdata),
        .host_ready (host_ready),
        .host_done  (host_done),
        .host_err   (host_err),
        .host_rdata (host_rdata),
        .int_req    (int_req),
        .int_we     (int_we),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .int_imp    (int_imp)
    );

endmodule

// File: tb/sim_apx_top.sv
`timescale 1ns/1ps
module sim_apx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adm_we = 1'b0;
    logic [4:0]  adm_addr = '0;
    logic [31:0] adm_wdata = '0;
    logic [31:0] adm_rdata;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_done, host_err;
    logic [31:0] host_rdata;
    logic        int_req, int_we;
    logic [31:0] int_addr, int_wdata, int_imp, int_rdata;
    logic [7:0]  win_valid;
    logic [255:0] imp_all;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    assign int_rdata = memf(int_addr);

    apx_top u0 (
        .clk(clk), .rst_n(rst_n),
        .adm_we(adm_we), .adm_addr(adm_addr), .adm_wdata(adm_wdata), .adm_rdata(adm_rdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_err(host_err), .host_rdata(host_rdata),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_imp(int_imp), .int_ack(int_req), .int_rdata(int_rdata),
        .win_valid(win_valid), .imp_all(imp_all)
    );

    // internal side observer
    logic        seen_req = 1'b0;
    logic        cap_we = 1'b0;
    logic [31:0] cap_addr = '0, cap_wdata = '0, cap_imp = '0;
    always @(negedge clk) begin
        if (int_req) begin
            seen_req  = 1'b1;
            cap_we    = int_we;
            cap_addr  = int_addr;
            cap_wdata = int_wdata;
            cap_imp   = int_imp;
        end
    end

    logic [31:0] base_m [8];
    logic [31:0] imp_m  [8];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic adm_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        adm_we = 1'b1; adm_addr = a; adm_wdata = d;
        @(negedge clk);
        adm_we = 1'b0;
    endtask

    task automatic adm_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        adm_addr = a;
        #1 d = adm_rdata;
    endtask

    task automatic acc(input logic we, input logic [14:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er, output logic dn);
        @(negedge clk);
        seen_req = 1'b0;
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        for (int n = 0; n < 8 && !host_done; n++) @(negedge clk);
        rd = host_rdata; er = host_err; dn = host_done;
    endtask

    // full expected-value check of one access against the bench model
    task automatic acc_check(input logic we, input logic [14:0] a, input logic [31:0] d);
        logic [31:0] rd, xa;
        logic er, dn;
        int w;
        w  = int'(a[14:12]);
        xa = {base_m[w][29:0], 2'b00} + {20'd0, a[11:0]};
        acc(we, a, d, rd, er, dn);
        chk("R4 done", {31'd0, dn}, 32'd1);
        if (base_m[w] == 32'hFFFF_FFFF) begin
            chk("R6 err", {31'd0, er}, 32'd1);
            chk("R6 rdata", rd, 32'hDEAD_BEEF);
            chk("R6 no int_req", {31'd0, seen_req}, 32'd0);
        end else begin
            chk("R3 int_addr", cap_addr, xa);
            chk("R12 int_imp", cap_imp, imp_m[w]);
            chk("R4 err", {31'd0, er}, 32'd0);
            chk("R4 int_we", {31'd0, cap_we}, {31'd0, we});
            if (we) chk("R4 int_wdata", cap_wdata, d);
            else    chk("R5 rdata", rd, memf(xa));
        end
    endtask

    task automatic set_base(input int w, input logic [31:0] v);
        adm_wr(5'(2*w), v);
        base_m[w] = v;
    endtask

    task automatic cmd(input logic [1:0] op, input int w, input logic [7:0] port,
                       input logic [15:0] fid);
        adm_wr(5'd16, {fid, port, 6'(w), op});
        if (op == 2'd0) begin
            for (int k = 0; k < 8; k++) base_m[k] = 32'hFFFF_FFFF;
        end else if (w >= 2) begin
            case (op)
                2'd1:    imp_m[w] = {16'h0007, fid};
                2'd2:    imp_m[w] = {4'h0, port, 4'hC, imp_m[w][15:0]};
                default: imp_m[w] = {16'h0004, imp_m[w][15:0]};
            endcase
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) begin base_m[k] = 32'hFFFF_FFFF; imp_m[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 win_valid", {24'd0, win_valid}, 32'd0);
        chk("R1 host_ready", {31'd0, host_ready}, 32'd1);
        chk("R1 imp_all", {31'd0, (imp_all == '0)}, 32'd1);
        adm_rd(5'd6, v);  chk("R1 base3", v, 32'hFFFF_FFFF);

        // R2 base programming and validity
        set_base(2, 32'h0000_1000);
        adm_rd(5'd4, v);  chk("R2 readback", v, 32'h0000_1000);
        chk("R2 valid", {24'd0, win_valid}, 32'h04);

        // R3 R5 R4 edges of a window
        acc_check(1'b0, 15'h2123, 32'h0);
        acc_check(1'b1, 15'h2FFC, 32'h0000_55AA);
        acc_check(1'b0, 15'h2000, 32'h0);
        // R6 invalid window
        acc_check(1'b0, 15'h5010, 32'h0);
        acc_check(1'b1, 15'h0004, 32'h1234_5678);

        // R7 R8 R9 impersonation sequence on window 2
        cmd(2'd1, 2, 8'h00, 16'hBEEF);
        adm_rd(5'd5, v); chk("R7 func word", v, 32'h0007_BEEF);
        acc_check(1'b0, 15'h2040, 32'h0);
        cmd(2'd2, 2, 8'h03, 16'h0000);
        adm_rd(5'd5, v); chk("R8 port word", v, 32'h003C_BEEF);
        cmd(2'd1, 2, 8'h00, 16'h1234);
        adm_rd(5'd5, v); chk("R7 port cleared", v, 32'h0007_1234);
        cmd(2'd3, 2, 8'h00, 16'h0000);
        adm_rd(5'd5, v); chk("R9 unport word", v, 32'h0004_1234);
        chk("R12 imp_all slice", imp_all[95:64], 32'h0004_1234);

        // R11 reserved windows
        cmd(2'd1, 0, 8'h00, 16'hAAAA);
        cmd(2'd2, 1, 8'h05, 16'h0000);
        adm_rd(5'd1, v); chk("R11 rsvd0 ignored", v, 32'h0);
        adm_rd(5'd3, v); chk("R11 rsvd1 ignored", v, 32'h0);
        adm_wr(5'd1, 32'h0000_0012); imp_m[0] = 32'h12;
        adm_rd(5'd1, v); chk("R11 raw write", v, 32'h0000_0012);

        // R2 all-ones invalidates a single window
        set_base(2, 32'hFFFF_FFFF);
        chk("R2 invalid", {24'd0, win_valid}, 32'h00);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0) begin
                int w;
                w = 2 + int'($urandom % 6);
                if ($urandom % 6 == 0) set_base(w, 32'hFFFF_FFFF);
                else                   set_base(w, $urandom);
            end else if (r == 1 && ($urandom % 4 == 0)) begin
                int w;
                w = int'($urandom % 8);
                set_base(w, $urandom & 32'h00FF_FFFF);
            end else begin
                acc_check(1'($urandom), 15'($urandom), $urandom);
            end
        end

        // R10 global invalidate
        set_base(3, 32'h0000_0200);
        set_base(7, 32'h0001_0000);
        chk("R10 pre", {24'd0, win_valid} & 32'h88, 32'h88);
        cmd(2'd0, 0, 8'h00, 16'h0000);
        chk("R10 all invalid", {24'd0, win_valid}, 32'h00);
        acc_check(1'b0, 15'h3008, 32'h0);

        finish_run();
    end

endmodule